// File: doc/BRIEF.md
# Planar Graphics Write/Read Datapath

This block sits between a byte-wide host port and four 8-bit memory planes of a planar frame buffer. Control values are loaded through a two-address register port: one address selects an internal register by number, the other writes the selected register. On a host write the block forms one data byte per plane from the host byte, the four latch bytes, a set/reset colour, a logic function and a bit mask. It also forms per-bit write enables gated by the plane mask input. On a host read it captures the four plane bytes presented by memory into its latches. It then returns either one chosen plane byte or a colour-compare byte.

A small controller with three states orders the work: `CTL_IDLE` (no request), `CTL_WRITE` (a host write was taken on the last edge) and `CTL_READ` (a host read was taken on the last edge). Every edge moves to `CTL_READ` if `host_rd` is high, else to `CTL_WRITE` if `host_wr` is high, else to `CTL_IDLE`. Every state can reach every other state, so a back-to-back request needs no idle cycle. All outputs are registered and show the result of a request one edge after it is sampled.

Top module: `gfx_plane_datapath`

## Requirements
- R1: After reset, `wr_strobe`, `rd_valid`, `plane_bit_we` and `host_rdata` are zero, the latches are zero, and all registers are zero except register 8, which is 0xFF. A write straight after reset therefore copies the host byte unchanged into every plane.
- R2: A write with `reg_addr`=0 stores `reg_wdata[3:0]` as the register number. A write with `reg_addr`=1 stores `reg_wdata` into that register. Numbers 6 and 9 to 15 address nothing, and data writes to them change no behaviour.
- R3: In write mode 0 (register 5 bits 1:0 = 00), the host byte is rotated right by register 3 bits 2:0 before use.
- R4: In write mode 0, each plane p whose bit p is set in register 1 takes 0xFF or 0x00 from bit p of register 0 in place of the rotated host byte.
- R5: In write modes 0 and 2, register 3 bits 4:3 combine the source byte with that plane's latch: 00 pass, 01 AND, 10 OR, 11 XOR.
- R6: In write modes 0 and 2, each bit cleared in register 8 yields the latch bit as data and a cleared write enable.
- R7: In write mode 1 (01), each plane receives its latch byte with all eight write enables set. Host data, the function and register 8 have no effect.
- R8: In write mode 2 (10), plane p receives 0xFF or 0x00 from host bit p, and then R5 and R6 apply. Write mode 3 (11) raises no write enable.
- R9: `plane_mask[p]`=0 clears all eight write enables of plane p in every write mode.
- R10: A host read loads all four `plane_rdata` bytes into the latches. In read mode 0 (register 5 bit 3 = 0), it returns the byte of the plane numbered by register 4 bits 1:0.
- R11: In read mode 1, result bit b is 1 when, for every plane p enabled by bit p of register 7, bit b of plane p equals bit p of register 2. With no plane enabled, the result is 0xFF.
- R12: Results appear one edge after the request. `host_rd` takes priority over `host_wr` in the same cycle, and the write is dropped with no write enable raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 1 | 0 = register number, 1 = register data |
| reg_wdata | input | 8 | Register port write byte |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_wdata | input | 8 | Host write byte |
| plane_mask | input | 4 | Per-plane write permission |
| plane_rdata | input | 32 | Plane bytes from memory, plane p at bits 8p+7:8p |
| wr_strobe | output | 1 | A write result is on the plane outputs |
| plane_wdata | output | 32 | Data byte per plane |
| plane_bit_we | output | 32 | Per-bit write enable per plane |
| rd_valid | output | 1 | `host_rdata` holds a new read result |
| host_rdata | output | 8 | Read result byte |

## Verification
Table-driven writes pair non-trivial latch bytes with asymmetric host bytes such as 0xA5 and 0x96. A wrong rotate direction, a plane-order swap or a confused logic function therefore gives a distinct wrong byte. The function codes are tried against the same latch contents, so AND, OR and XOR cannot be mistaken for one another. Partial bit masks and partial plane masks show whether the latch bits and enables are merged per bit or per plane. Directed reads with compare colours that match some planes in only some columns separate the "all enabled planes" rule from an any-plane rule. A cleared care mask shows the all-ones case. A read and write in the same cycle shows the priority order.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
    localparam int PLANES  = 4;
    localparam int BYTE_W  = 8;
    localparam int BUS_W   = PLANES * BYTE_W;
    localparam int IDX_W   = 4;
    localparam int ROT_W   = $clog2(BYTE_W);
    localparam int PSEL_W  = $clog2(PLANES);

    localparam logic [1:0] WM_DIRECT = 2'b00;
    localparam logic [1:0] WM_LATCH  = 2'b01;
    localparam logic [1:0] WM_EXPAND = 2'b10;

    localparam logic [1:0] FN_PASS = 2'b00;
    localparam logic [1:0] FN_AND  = 2'b01;
    localparam logic [1:0] FN_OR   = 2'b10;
    localparam logic [1:0] FN_XOR  = 2'b11;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_WRITE = 2'd1,
        CTL_READ  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [PLANES-1:0] setrst;
        logic [PLANES-1:0] sr_en;
        logic [PLANES-1:0] cmp_color;
        logic [ROT_W-1:0]  rot;
        logic [1:0]        func;
        logic [PSEL_W-1:0] rd_plane;
        logic [1:0]        wmode;
        logic              rmode;
        logic [PLANES-1:0] cmp_care;
        logic [BYTE_W-1:0] bitmask;
    } gfx_cfg_t;
endpackage

// File: rtl/gfx_cfg_regs.sv
module gfx_cfg_regs
    import gfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output gfx_cfg_t          cfg
);
    logic [IDX_W-1:0] index_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q     <= '0;
            cfg         <= '0;
            cfg.bitmask <= '1;
        end else if (reg_wr) begin
            if (!reg_addr) begin
                index_q <= reg_wdata[IDX_W-1:0];
            end else begin
                case (index_q)
                    4'd0: cfg.setrst    <= reg_wdata[PLANES-1:0];
                    4'd1: cfg.sr_en     <= reg_wdata[PLANES-1:0];
                    4'd2: cfg.cmp_color <= reg_wdata[PLANES-1:0];
                    4'd3: begin
                        cfg.rot  <= reg_wdata[ROT_W-1:0];
                        cfg.func <= reg_wdata[ROT_W+1:ROT_W];
                    end
                    4'd4: cfg.rd_plane  <= reg_wdata[PSEL_W-1:0];
                    4'd5: begin
                        cfg.wmode <= reg_wdata[1:0];
                        cfg.rmode <= reg_wdata[3];
                    end
                    4'd7: cfg.cmp_care  <= reg_wdata[PLANES-1:0];
                    4'd8: cfg.bitmask   <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R2: data writes to unused register numbers leave the configuration alone
    assert_hi_index_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && (index_q > 4'd8 || index_q == 4'd6)) |=> $stable(cfg));
endmodule

// File: rtl/gfx_wr_path.sv
module gfx_wr_path
    import gfx_pkg::*;
(
    input  gfx_cfg_t          cfg,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [PLANES-1:0] plane_mask,
    input  logic [BUS_W-1:0]  latch,
    output logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  bit_we
);
    logic [2*BYTE_W-1:0] doubled;
    logic [BYTE_W-1:0]   rotated;

    always_comb begin
        doubled = {host_wdata, host_wdata} >> cfg.rot;
        rotated = doubled[BYTE_W-1:0];
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [BYTE_W-1:0] lat, src, fn, merged, d_out, we_out;

        always_comb begin
            lat = latch[p*BYTE_W +: BYTE_W];
            if (cfg.wmode == WM_EXPAND)  src = {BYTE_W{host_wdata[p]}};
            else if (cfg.sr_en[p])       src = {BYTE_W{cfg.setrst[p]}};
            else                         src = rotated;
            unique case (cfg.func)
                FN_PASS: fn = src;
                FN_AND:  fn = src & lat;
                FN_OR:   fn = src | lat;
                FN_XOR:  fn = src ^ lat;
            endcase
            merged = (fn & cfg.bitmask) | (lat & ~cfg.bitmask);
            unique case (cfg.wmode)
                WM_LATCH: begin
                    d_out  = lat;
                    we_out = {BYTE_W{plane_mask[p]}};
                end
                WM_DIRECT, WM_EXPAND: begin
                    d_out  = merged;
                    we_out = {BYTE_W{plane_mask[p]}} & cfg.bitmask;
                end
                default: begin
                    d_out  = merged;
                    we_out = '0;
                end
            endcase
        end

        assign wdata[p*BYTE_W +: BYTE_W]  = d_out;
        assign bit_we[p*BYTE_W +: BYTE_W] = we_out;
    end
endmodule

// File: rtl/gfx_rd_path.sv
module gfx_rd_path
    import gfx_pkg::*;
(
    input  gfx_cfg_t          cfg,
    input  logic [BUS_W-1:0]  plane_rdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] cmp_byte;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic [PLANES-1:0] column;
        for (genvar p = 0; p < PLANES; p++) begin : g_col
            assign column[p] = plane_rdata[p*BYTE_W + b];
        end
        assign cmp_byte[b] = &(~cfg.cmp_care | ~(column ^ cfg.cmp_color));
    end

    always_comb begin
        if (cfg.rmode) rdata = cmp_byte;
        else           rdata = plane_rdata[cfg.rd_plane*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/gfx_plane_datapath.sv
module gfx_plane_datapath
    import gfx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_addr,
    input  logic [7:0]               reg_wdata,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [7:0]               host_wdata,
    input  logic [3:0]               plane_mask,
    input  logic [31:0]              plane_rdata,
    output logic                     wr_strobe,
    output logic [31:0]              plane_wdata,
    output logic [31:0]              plane_bit_we,
    output logic                     rd_valid,
    output logic [7:0]               host_rdata
);
    gfx_cfg_t          cfg;
    ctl_state_e        state_q, state_d;
    logic [BUS_W-1:0]  latch_q;
    logic [BUS_W-1:0]  wr_data, wr_we;
    logic [BYTE_W-1:0] rd_result;

    gfx_cfg_regs i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg(cfg)
    );

    gfx_wr_path i_wr (
        .cfg(cfg), .host_wdata(host_wdata), .plane_mask(plane_mask),
        .latch(latch_q), .wdata(wr_data), .bit_we(wr_we)
    );

    gfx_rd_path i_rd (
        .cfg(cfg), .plane_rdata(plane_rdata), .rdata(rd_result)
    );

    always_comb begin
        if (host_rd)      state_d = CTL_READ;
        else if (host_wr) state_d = CTL_WRITE;
        else              state_d = CTL_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q      <= '0;
            host_rdata   <= '0;
            plane_wdata  <= '0;
            plane_bit_we <= '0;
        end else begin
            unique case (state_d)
                CTL_READ: begin
                    latch_q      <= plane_rdata;
                    host_rdata   <= rd_result;
                    plane_bit_we <= '0;
                end
                CTL_WRITE: begin
                    plane_wdata  <= wr_data;
                    plane_bit_we <= wr_we;
                end
                default: plane_bit_we <= '0;
            endcase
        end
    end

    assign wr_strobe = (state_q == CTL_WRITE);
    assign rd_valid  = (state_q == CTL_READ);

    // R10: a read captures every plane byte and flags the result
    assert_read_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> (rd_valid && latch_q == $past(plane_rdata)));

    // R12: read wins over a simultaneous write
    assert_read_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_wr) |=> (!wr_strobe && plane_bit_we == '0));

    // R12: no enables without an accepted write
    assert_no_stray_we_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr || host_rd) |=> (plane_bit_we == '0));

    // R7: latch-copy mode forwards the latch bytes
    assert_latch_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && cfg.wmode == WM_LATCH) |=> (plane_wdata == latch_q));

    // R6: masked-off bits carry the latch value
    assert_mask_keeps_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && cfg.wmode != WM_LATCH) |=>
        (((plane_wdata ^ latch_q) & ~{PLANES{$past(cfg.bitmask)}}) == '0));

    for (genvar p = 0; p < PLANES; p++) begin : g_chk
        // R9: a cleared plane mask bit blocks that plane
        assert_plane_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && !host_rd && !plane_mask[p]) |=>
            (plane_bit_we[p*BYTE_W +: BYTE_W] == '0));
    end
endmodule

// File: tb/test_gfx_plane_datapath.sv
module test_gfx_plane_datapath;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] lat;
        logic [7:0]  r3;
        logic [3:0]  r1;
        logic [3:0]  r0;
        logic [7:0]  msk;
        logic [1:0]  wm;
        logic [7:0]  host;
        logic [3:0]  pm;
        logic [7:0]  tag;
    } vec_t;

    // tags: R3 rotate, R4 set/reset, R5 functions, R6 bit mask, R9 plane mask, R8 expand
    localparam vec_t VECS [8] = '{
        '{32'h12345678, 8'h03, 4'h0, 4'h0, 8'hFF, 2'b00, 8'hA5, 4'hF, 8'd3},
        '{32'h0F0F0F0F, 8'h00, 4'h5, 4'h4, 8'hFF, 2'b00, 8'h96, 4'hF, 8'd4},
        '{32'hF0CC3355, 8'h08, 4'h0, 4'h0, 8'hFF, 2'b00, 8'h96, 4'hF, 8'd5},
        '{32'hF0CC3355, 8'h10, 4'h0, 4'h0, 8'hFF, 2'b00, 8'h96, 4'hF, 8'd5},
        '{32'hF0CC3355, 8'h19, 4'h0, 4'h0, 8'hFF, 2'b00, 8'h96, 4'hF, 8'd5},
        '{32'hA1B2C3D4, 8'h00, 4'h0, 4'h0, 8'h0F, 2'b00, 8'h5A, 4'hF, 8'd6},
        '{32'h11223344, 8'h00, 4'h0, 4'h0, 8'hFF, 2'b00, 8'h77, 4'h6, 8'd9},
        '{32'h3C3C3C3C, 8'h18, 4'h0, 4'h0, 8'hF0, 2'b10, 8'h0A, 4'hF, 8'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [3:0]  plane_mask = '0;
    logic [31:0] plane_rdata = '0;
    logic        wr_strobe, rd_valid;
    logic [31:0] plane_wdata, plane_bit_we;
    logic [7:0]  host_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    gfx_plane_datapath i_gfx_plane_datapath (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .plane_mask(plane_mask), .plane_rdata(plane_rdata),
        .wr_strobe(wr_strobe), .plane_wdata(plane_wdata), .plane_bit_we(plane_bit_we),
        .rd_valid(rd_valid), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_set(input logic [3:0] idx, input logic [7:0] val);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = {4'h0, idx};
        @(negedge clk); reg_addr = 1'b1; reg_wdata = val;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] planes);
        @(negedge clk); host_rd = 1'b1; plane_rdata = planes;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d, input logic [3:0] pm);
        @(negedge clk); host_wr = 1'b1; host_wdata = d; plane_mask = pm;
        @(negedge clk); host_wr = 1'b0;
    endtask

    // reference write: returns {data, enables}
    function automatic logic [63:0] ref_write(input logic [31:0] lat, input logic [7:0] r3,
            input logic [3:0] r1, input logic [3:0] r0, input logic [7:0] msk,
            input logic [1:0] wm, input logic [7:0] host, input logic [3:0] pm);
        logic [31:0] d, we;
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 8; b++) begin
                logic s, l, f;
                l = lat[p*8+b];
                if (wm == 2'b10)  s = host[p];
                else if (r1[p])   s = r0[p];
                else              s = host[(b + int'(r3[2:0])) % 8];
                case (r3[4:3])
                    2'b00: f = s;
                    2'b01: f = s & l;
                    2'b10: f = s | l;
                    default: f = s ^ l;
                endcase
                if (wm == 2'b01) begin
                    d[p*8+b] = l;  we[p*8+b] = pm[p];
                end else begin
                    d[p*8+b] = msk[b] ? f : l;
                    we[p*8+b] = (wm == 2'b11) ? 1'b0 : (pm[p] & msk[b]);
                end
            end
        end
        return {d, we};
    endfunction

    function automatic logic [7:0] ref_compare(input logic [31:0] planes,
            input logic [3:0] color, input logic [3:0] care);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            r[b] = 1'b1;
            for (int p = 0; p < 4; p++)
                if (care[p] && planes[p*8+b] != color[p]) r[b] = 1'b0;
        end
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs
        check("R1 reset flags", {62'b0, wr_strobe, rd_valid}, 64'd0);
        check("R1 reset enables/rdata", {24'b0, plane_bit_we, host_rdata}, 64'd0);
        // R1: default registers pass host data to all planes
        do_write(8'h3C, 4'hF);
        check("R1 default write", {plane_wdata, plane_bit_we}, {32'h3C3C3C3C, 32'hFFFFFFFF});
        check("R12 write strobe", {63'b0, wr_strobe}, 64'd1);

        // R2: data write to register 9 and 6 has no effect
        reg_set(4'd9, 8'h0F);
        reg_set(4'd6, 8'hFF);
        do_write(8'h5A, 4'hF);
        check("R2 unused index ignored", {plane_wdata, plane_bit_we}, {32'h5A5A5A5A, 32'hFFFFFFFF});

        // table of write vectors
        foreach (VECS[i]) begin
            reg_set(4'd5, 8'h00);
            reg_set(4'd4, 8'h00);
            do_read(VECS[i].lat);
            check("R10 read plane 0", {56'b0, host_rdata}, {56'b0, VECS[i].lat[7:0]});
            reg_set(4'd0, {4'h0, VECS[i].r0});
            reg_set(4'd1, {4'h0, VECS[i].r1});
            reg_set(4'd3, VECS[i].r3);
            reg_set(4'd8, VECS[i].msk);
            reg_set(4'd5, {6'b0, VECS[i].wm});
            do_write(VECS[i].host, VECS[i].pm);
            e = ref_write(VECS[i].lat, VECS[i].r3, VECS[i].r1, VECS[i].r0,
                          VECS[i].msk, VECS[i].wm, VECS[i].host, VECS[i].pm);
            check($sformatf("R%0d vector %0d", VECS[i].tag, i), {plane_wdata, plane_bit_we}, e);
        end

        // R7: latch copy ignores host data, function and mask
        reg_set(4'd5, 8'h00);
        do_read(32'hDEADBEEF);
        reg_set(4'd3, 8'h18);
        reg_set(4'd8, 8'h00);
        reg_set(4'd5, 8'h01);
        do_write(8'h00, 4'hB);
        check("R7 latch copy", {plane_wdata, plane_bit_we}, {32'hDEADBEEF, 32'hFF00FFFF});

        // R8: mode 3 raises no enable
        reg_set(4'd8, 8'hFF);
        reg_set(4'd5, 8'h03);
        do_write(8'hFF, 4'hF);
        check("R8 mode 3 no enables", {32'b0, plane_bit_we}, 64'd0);

        // R10: read mode 0 with plane 2 selected
        reg_set(4'd5, 8'h00);
        reg_set(4'd4, 8'h02);
        do_read(32'h44332211);
        check("R10 read plane 2", {63'b0, rd_valid, host_rdata}, {55'b0, 1'b1, 8'h33});

        // R11: colour compare
        reg_set(4'd2, 8'h05);
        reg_set(4'd7, 8'h0F);
        reg_set(4'd5, 8'h08);
        do_read(32'h00AACCF0);
        check("R11 compare all planes", {56'b0, host_rdata},
              {56'b0, ref_compare(32'h00AACCF0, 4'h5, 4'hF)});
        reg_set(4'd7, 8'h03);
        do_read(32'h00AACCF0);
        check("R11 compare planes 0-1", {56'b0, host_rdata},
              {56'b0, ref_compare(32'h00AACCF0, 4'h5, 4'h3)});
        reg_set(4'd7, 8'h00);
        do_read(32'h12345678);
        check("R11 no plane enabled", {56'b0, host_rdata}, {56'b0, 8'hFF});

        // R12: simultaneous read and write, read wins
        reg_set(4'd5, 8'h01);
        @(negedge clk); host_rd = 1'b1; host_wr = 1'b1; plane_rdata = 32'hCAFEF00D;
        host_wdata = 8'h00; plane_mask = 4'hF;
        @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
        check("R12 read priority", {30'b0, rd_valid, wr_strobe, plane_bit_we}, {30'b0, 2'b10, 32'h0});
        do_write(8'h00, 4'hF);
        check("R12 latches from read", {plane_wdata, plane_bit_we}, {32'hCAFEF00D, 32'hFFFFFFFF});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule